// File: doc/BRIEF.md
# Single-Line Bus-Cycle Serial Memory Controller

This block is the device-side control logic of a 512-byte nonvolatile memory. A host processor reaches it with ordinary bus read and write cycles, using a chip-enable strobe, an output-enable strobe, a write-enable strobe and a single data bit. Every bus write cycle shifts one bit into the block, and every bus read cycle shifts one bit out. Opcodes are never sent. The order of plain read and write cycles alone selects an operation: a reset, an address load, a sequential byte read, a page load or a commit.

All strobes are sampled on a fast system clock. A write cycle is taken when it ends, which is the first rising edge of write-enable or chip-enable. The storage array is a register array. The self-timed programming step is a counter, and its length is set by a parameter in clock cycles. A write-protect input, a write-enable latch and a busy indication decide whether a commit may start and what a read returns while one is running.

The data bit is split into an input, an output and an output-enable, so that the pad cell above the block can form the tristate line.

Top module: `sbl_mem_ctrl`

## Requirements
- R1: The sequence read cycle, write cycle carrying 0, read cycle is a reset. It abandons any sequential read or page load, and the block then waits for a new address. If `wp_n` is high at that moment, the reset also sets the write-enable latch.
- R2: After a reset, 16 write cycles with no read between them load the address, most significant bit first. Only the last 9 bits received form the byte address; the first 7 are ignored.
- R3: Read cycles that follow a completed address return bytes from the array. Each byte comes out over 8 read cycles, bit 7 first. The address then steps up by one and wraps from 0x1FF to 0x000.
- R4: If write cycles follow a completed address, they load whole bytes into the 8-byte page that holds that address (the page base has address bits [2:0] = 000). Loading starts at the addressed column and wraps within the page, so the ninth byte overwrites the first one.
- R5: After a complete page load, the sequence read, write carrying 1, read starts a commit that lasts COMMIT_CYCLES clocks. When it ends, only the bytes that were loaded are written into the array. The other bytes of the page keep their old values.
- R6: A page load that ends with a partly loaded byte never starts a commit.
- R7: The write-enable latch is clear after power-up and after each commit, and it stays clear while `wp_n` is low. A commit starts only when the latch is set and `wp_n` is high.
- R8: While a commit runs, every read cycle returns 0 and every cycle sequence is ignored, a reset included. Once the commit is over, reads return 1.
- R9: Taking `wp_n` low during a commit does not stop or change that commit.
- R10: `dq_oe` is high only while both `ce_n` and `oe_n` are low. It is low whenever `ce_n` is high and during write cycles.
- R11: A read cycle taken while the block is not in sequential read mode returns 1. This covers the time after power-up, after a reset and after a commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus strobes |
| rst | input | 1 | Synchronous active-high power-up reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| wp_n | input | 1 | Write protect, low blocks commits |
| dq_in | input | 1 | Data bit from the pad |
| dq_out | output | 1 | Data bit to the pad |
| dq_oe | output | 1 | Pad output enable for the data bit |

## Verification
The assertions run on every cycle and check the following. The data line is never driven while chip-enable is high. The data line reads 0 whenever the busy state is on. The write-enable latch is clear in the cycle after `wp_n` is low. A commit starts only from a set latch. Every commit lasts exactly the configured number of cycles. The bench scenarios cover the rest, all of it sequence-dependent: address aliasing of the top seven bits, MSB-first byte order, address wrap at the top of the array, column wrap within a page with overwrite, untouched bytes after a partial page, incomplete loads being refused, and a reset or a write-protect change landing in the middle of a running commit. The bench checks each of these against a byte model of the array that it keeps itself.

// File: rtl/sbl_pkg.sv
package sbl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AREADY,
        ST_RDATA,
        ST_LOAD,
        ST_ARMED,
        ST_ARMED1
    } sbl_state_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic bitv;
    } bus_ev_t;

    typedef struct packed {
        logic valid;
        logic is_rd;
        logic bitv;
    } hist_t;

    function automatic hist_t ev_to_hist(bus_ev_t ev);
        hist_t h;
        h.valid = ev.rd | ev.wr;
        h.is_rd = ev.rd;
        h.bitv  = ev.bitv;
        return h;
    endfunction

    // newest = write carrying 0, older = read
    function automatic logic is_reset_pat(hist_t newest, hist_t older);
        return newest.valid && !newest.is_rd && !newest.bitv &&
               older.valid && older.is_rd;
    endfunction

endpackage

// File: rtl/sbl_strobe_dec.sv
module sbl_strobe_dec
    import sbl_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    ce_n,
    input  logic    oe_n,
    input  logic    we_n,
    input  logic    dq_in,
    output bus_ev_t ev_o
);
    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic dq;
    } pin_s_t;

    pin_s_t cur_q, prv_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq: 1'b0};
            prv_q <= '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq: 1'b0};
        end else begin
            cur_q <= '{ce_n: ce_n, oe_n: oe_n, we_n: we_n, dq: dq_in};
            prv_q <= cur_q;
        end
    end

    logic wr_now, wr_was, rd_now, rd_was;
    assign wr_now = !cur_q.ce_n && !cur_q.we_n && cur_q.oe_n;
    assign wr_was = !prv_q.ce_n && !prv_q.we_n && prv_q.oe_n;
    assign rd_now = !cur_q.ce_n && !cur_q.oe_n && cur_q.we_n;
    assign rd_was = !prv_q.ce_n && !prv_q.oe_n && prv_q.we_n;

    always_comb begin
        ev_o.wr   = wr_was && !wr_now;
        ev_o.rd   = rd_was && !rd_now;
        ev_o.bitv = prv_q.dq;
    end
endmodule

// File: rtl/sbl_page_buf.sv
module sbl_page_buf #(
    parameter int PAGE_W = 3,
    localparam int PAGE_BYTES = 1 << PAGE_W
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clr,
    input  logic                         wr_en,
    input  logic [PAGE_W-1:0]            idx,
    input  logic [7:0]                   data,
    output logic [PAGE_BYTES-1:0][7:0]   bytes_o,
    output logic [PAGE_BYTES-1:0]        mask_o
);
    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                mask_o[g]  <= 1'b0;
                bytes_o[g] <= '0;
            end else if (wr_en && idx == PAGE_W'(g)) begin
                mask_o[g]  <= 1'b1;
                bytes_o[g] <= data;
            end
        end
    end
endmodule

// File: rtl/sbl_commit_timer.sv
module sbl_commit_timer #(
    parameter int COMMIT_CYCLES = 64,
    localparam int CW = $clog2(COMMIT_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy_o,
    output logic done_o
);
    logic [CW-1:0] cnt_q;

    assign done_o = busy_o && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_o <= 1'b0;
            cnt_q  <= '0;
        end else if (!busy_o && start) begin
            busy_o <= 1'b1;
            cnt_q  <= CW'(COMMIT_CYCLES - 1);
        end else if (busy_o) begin
            if (cnt_q == '0) busy_o <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/sbl_mem_ctrl.sv
module sbl_mem_ctrl
    import sbl_pkg::*;
#(
    parameter int ADDR_W        = 9,
    parameter int PAGE_W        = 3,
    parameter int FRAME_BITS    = 16,
    parameter int COMMIT_CYCLES = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    input  logic wp_n,
    input  logic dq_in,
    output logic dq_out,
    output logic dq_oe
);
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int ACNT_W     = $clog2(FRAME_BITS + 1);
    localparam int PG_ADDR_W  = ADDR_W - PAGE_W;

    bus_ev_t              ev;
    sbl_state_e           state_q;
    hist_t                h1_q, h2_q;
    logic [ADDR_W-1:0]    addr_q;
    logic [ACNT_W-1:0]    acnt_q;
    logic [2:0]           rbit_q, wbit_q;
    logic [6:0]           shift_q;
    logic [PAGE_W-1:0]    col_q;
    logic [PG_ADDR_W-1:0] page_q;
    logic                 wel;
    logic                 busy, commit_done;
    logic                 rst_seq, commit_go, pb_clr, pb_wr;
    logic [PAGE_BYTES-1:0][7:0] pg_data;
    logic [PAGE_BYTES-1:0]      pg_mask;
    logic [7:0]           mem [DEPTH];

    sbl_strobe_dec i_dec (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .dq_in(dq_in), .ev_o(ev)
    );

    sbl_page_buf #(.PAGE_W(PAGE_W)) i_pbuf (
        .clk(clk), .rst(rst), .clr(pb_clr), .wr_en(pb_wr), .idx(col_q),
        .data({shift_q, ev.bitv}), .bytes_o(pg_data), .mask_o(pg_mask)
    );

    sbl_commit_timer #(.COMMIT_CYCLES(COMMIT_CYCLES)) i_timer (
        .clk(clk), .rst(rst), .start(commit_go), .busy_o(busy),
        .done_o(commit_done)
    );

    assign rst_seq   = !busy && ev.rd && is_reset_pat(h1_q, h2_q);
    assign commit_go = !busy && ev.rd && !rst_seq && state_q == ST_ARMED1
                       && wel && wp_n;
    assign pb_wr     = !busy && ev.wr && state_q == ST_LOAD && (&wbit_q);
    assign pb_clr    = rst_seq || commit_done ||
                       (!busy && ev.wr && state_q == ST_AREADY);

    // write-enable latch
    always_ff @(posedge clk) begin
        if (rst)              wel <= 1'b0;
        else if (!wp_n)       wel <= 1'b0;
        else if (commit_done) wel <= 1'b0;
        else if (rst_seq)     wel <= 1'b1;
    end

    // sequence decoder
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            h1_q    <= '0;
            h2_q    <= '0;
            addr_q  <= '0;
            acnt_q  <= '0;
            rbit_q  <= '0;
            wbit_q  <= '0;
            shift_q <= '0;
            col_q   <= '0;
            page_q  <= '0;
        end else if (busy) begin
            state_q <= ST_IDLE;
            h1_q    <= '0;
            h2_q    <= '0;
        end else if (ev.rd || ev.wr) begin
            h1_q <= ev_to_hist(ev);
            h2_q <= h1_q;
            if (rst_seq) begin
                state_q <= ST_ADDR;
                acnt_q  <= '0;
            end else begin
                unique case (state_q)
                    ST_IDLE: state_q <= ST_IDLE;
                    ST_ADDR: begin
                        if (ev.wr) begin
                            addr_q <= {addr_q[ADDR_W-2:0], ev.bitv};
                            acnt_q <= acnt_q + 1'b1;
                            if (acnt_q == ACNT_W'(FRAME_BITS - 1)) begin
                                state_q <= ST_AREADY;
                                rbit_q  <= '0;
                            end
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end
                    ST_AREADY, ST_RDATA: begin
                        if (ev.rd) begin
                            state_q <= ST_RDATA;
                            rbit_q  <= rbit_q + 1'b1;
                            if (&rbit_q) addr_q <= addr_q + 1'b1;
                        end else if (state_q == ST_AREADY) begin
                            state_q <= ST_LOAD;
                            shift_q <= {6'd0, ev.bitv};
                            wbit_q  <= 3'd1;
                            col_q   <= addr_q[PAGE_W-1:0];
                            page_q  <= addr_q[ADDR_W-1:PAGE_W];
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end
                    ST_LOAD: begin
                        if (ev.wr) begin
                            shift_q <= {shift_q[5:0], ev.bitv};
                            wbit_q  <= wbit_q + 1'b1;
                            if (&wbit_q) col_q <= col_q + 1'b1;
                        end else if (wbit_q == '0 && (|pg_mask)) begin
                            state_q <= ST_ARMED;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end
                    ST_ARMED:  state_q <= (ev.wr && ev.bitv) ? ST_ARMED1 : ST_IDLE;
                    ST_ARMED1: state_q <= ST_IDLE;
                    default:   state_q <= ST_IDLE;
                endcase
            end
        end
    end

    // storage array, written only at the end of a commit
    always_ff @(posedge clk) begin
        if (commit_done) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (pg_mask[i]) mem[{page_q, PAGE_W'(i)}] <= pg_data[i];
            end
        end
    end

    logic [7:0] rd_byte;
    assign rd_byte = mem[addr_q];

    always_comb begin
        if (busy)
            dq_out = 1'b0;
        else if (state_q == ST_AREADY || state_q == ST_RDATA)
            dq_out = rd_byte[3'd7 - rbit_q];
        else
            dq_out = 1'b1;
    end

    assign dq_oe = !ce_n && !oe_n;
endmodule

// File: rtl/sbl_mem_checker.sv
module sbl_mem_checker #(
    parameter int COMMIT_CYCLES = 64,
    localparam int LW = $clog2(COMMIT_CYCLES + 2)
) (
    input logic clk,
    input logic rst,
    input logic ce_n,
    input logic wp_n,
    input logic dq_out,
    input logic dq_oe,
    input logic busy,
    input logic wel
);
    logic [LW-1:0] run_len;

    always_ff @(posedge clk) begin
        if (rst)       run_len <= '0;
        else if (busy) run_len <= run_len + 1'b1;
        else           run_len <= '0;
    end

    AST_NO_DRIVE_DESEL: assert property (@(posedge clk) disable iff (rst)
        ce_n |-> !dq_oe); // R10

    AST_BUSY_READS_LOW: assert property (@(posedge clk) disable iff (rst)
        (busy && dq_oe) |-> !dq_out); // R8

    AST_WP_CLEARS_WEL: assert property (@(posedge clk) disable iff (rst)
        !wp_n |=> !wel); // R7

    AST_COMMIT_NEEDS_WEL: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(wel)); // R7

    AST_COMMIT_LENGTH: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> run_len == LW'(COMMIT_CYCLES)); // R5
endmodule

bind sbl_mem_ctrl sbl_mem_checker #(.COMMIT_CYCLES(COMMIT_CYCLES)) i_chk (
    .clk(clk), .rst(rst), .ce_n(ce_n), .wp_n(wp_n), .dq_out(dq_out),
    .dq_oe(dq_oe), .busy(busy), .wel(wel)
);

// File: tb/test_sbl_mem_ctrl.sv
module test_sbl_mem_ctrl;
    localparam int CYC = 300;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, wp_n = 1'b1, dq_in = 1'b0;
    logic dq_out, dq_oe;

    int checks = 0;
    int failures = 0;
    logic [7:0] model [512];

    always #10 clk = ~clk;

    sbl_mem_ctrl #(.COMMIT_CYCLES(CYC)) i_sbl_mem_ctrl (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .wp_n(wp_n), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_cyc(input logic b);
        @(negedge clk);
        dq_in = b; ce_n = 1'b0; we_n = 1'b0;
        repeat (2) @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic rd_cyc(output logic b, output logic oe_seen);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0;
        repeat (2) @(negedge clk);
        b = dq_out; oe_seen = dq_oe;
        oe_n = 1'b1; ce_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic rd_bit(output logic b);
        logic o;
        rd_cyc(b, o);
    endtask

    task automatic seq_reset();
        logic b;
        rd_bit(b); wr_cyc(1'b0); rd_bit(b);
    endtask

    task automatic send_addr(input logic [15:0] a);
        for (int i = 15; i >= 0; i--) wr_cyc(a[i]);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) wr_cyc(v[i]);
    endtask

    task automatic read_byte(output logic [7:0] v);
        for (int i = 7; i >= 0; i--) rd_bit(v[i]);
    endtask

    task automatic seq_commit();
        logic b;
        rd_bit(b); wr_cyc(1'b1); rd_bit(b);
    endtask

    task automatic wait_commit();
        repeat (CYC + 20) @(negedge clk);
    endtask

    task automatic check_at(input int a, input string req);
        logic [7:0] v;
        seq_reset();
        send_addr(16'(a));
        read_byte(v);
        chk(v === model[a], req, v, model[a]);
    endtask

    // write n bytes starting at a, modelling the page wrap from the requirements
    task automatic page_write(input int a, input int n, input logic [7:0] base);
        seq_reset();
        send_addr(16'(a));
        for (int k = 0; k < n; k++) begin
            send_byte(base + 8'(k));
            model[(a & 9'h1F8) | ((a + k) & 7)] = base + 8'(k);
        end
        seq_commit();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic b, o;
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state
        chk(dq_oe === 1'b0, "R10 idle oe", dq_oe, 0);
        rd_cyc(b, o);
        chk(b === 1'b1, "R11 read after power-up", b, 1);
        chk(o === 1'b1, "R10 oe during read", o, 1);

        // R10: no drive while deselected or during a write cycle
        @(negedge clk); oe_n = 1'b0; @(negedge clk);
        chk(dq_oe === 1'b0, "R10 oe with ce high", dq_oe, 0);
        oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0; @(negedge clk);
        chk(dq_oe === 1'b0, "R10 oe in write", dq_oe, 0);
        we_n = 1'b1; ce_n = 1'b1; repeat (3) @(negedge clk);

        // full page at 0x010, junk in the 7 ignored address bits (R2)
        seq_reset();
        send_addr(16'hFE10);
        for (int k = 0; k < 8; k++) begin
            send_byte(8'h11 + 8'(k));
            model[16 + k] = 8'h11 + 8'(k);
        end
        seq_commit();
        rd_bit(b);
        chk(b === 1'b0, "R8 read during commit", b, 0);
        wait_commit();
        rd_bit(b);
        chk(b === 1'b1, "R8 read after commit", b, 1);

        // sequential read of the page (R3, R2)
        seq_reset();
        send_addr(16'h0010);
        for (int k = 0; k < 8; k++) begin
            read_byte(v);
            chk(v === model[16 + k], "R3 sequential byte", v, model[16 + k]);
        end

        // R1/R11: reset aborts sequential read, reads then return 1
        seq_reset();
        rd_bit(b);
        chk(b === 1'b1, "R1 read after abort", b, 1);
        rd_bit(b);
        chk(b === 1'b1, "R11 further read", b, 1);

        // R5: partial page keeps other bytes
        page_write(9'h012, 2, 8'h77);
        wait_commit();
        check_at(9'h011, "R5 byte before kept");
        check_at(9'h012, "R5 loaded byte");
        check_at(9'h013, "R5 loaded byte 2");
        check_at(9'h014, "R5 byte after kept");

        // R4: column wrap within page, and ninth byte overwrites first
        page_write(9'h025, 4, 8'hA0);
        wait_commit();
        check_at(9'h027, "R4 end of page");
        check_at(9'h020, "R4 wrapped column");
        page_write(9'h030, 9, 8'hB0);
        wait_commit();
        check_at(9'h030, "R4 overwrite");
        check_at(9'h037, "R4 last column");

        // R3: wrap at the top of the array
        page_write(9'h1F8, 8, 8'hC0);
        wait_commit();
        page_write(9'h000, 8, 8'hD0);
        wait_commit();
        seq_reset();
        send_addr(16'h01FF);
        read_byte(v);
        chk(v === model[511], "R3 top byte", v, model[511]);
        read_byte(v);
        chk(v === model[0], "R3 wrap to zero", v, model[0]);

        // R6: incomplete byte refuses commit
        seq_reset();
        send_addr(16'h0010);
        send_byte(8'hFF);
        for (int i = 0; i < 4; i++) wr_cyc(1'b1);
        seq_commit();
        rd_bit(b);
        chk(b === 1'b1, "R6 no busy after partial", b, 1);
        check_at(9'h010, "R6 array unchanged");

        // R7: write protect low blocks the latch
        wp_n = 1'b0;
        seq_reset();
        send_addr(16'h0010);
        send_byte(8'h55);
        seq_commit();
        rd_bit(b);
        chk(b === 1'b1, "R7 protected no commit", b, 1);
        seq_reset();
        send_addr(16'h0010);
        send_byte(8'h56);
        wp_n = 1'b1;
        seq_commit();
        rd_bit(b);
        chk(b === 1'b1, "R7 latch not set by protected reset", b, 1);
        check_at(9'h010, "R7 array unchanged");

        // R8/R9: reset and write-protect during a commit
        page_write(9'h040, 8, 8'hE0);
        rd_bit(b);
        chk(b === 1'b0, "R8 busy read", b, 0);
        wr_cyc(1'b0);
        rd_bit(b);
        chk(b === 1'b0, "R8 reset ignored while busy", b, 0);
        wp_n = 1'b0;
        rd_bit(b);
        chk(b === 1'b0, "R9 still busy with wp low", b, 0);
        wait_commit();
        wp_n = 1'b1;
        check_at(9'h040, "R9 commit completed");
        check_at(9'h047, "R9 commit last byte");

        // R7: latch cleared after a commit, so a new commit needs a fresh reset
        seq_reset();
        send_addr(16'h0048);
        send_byte(8'h99);
        seq_commit();
        rd_bit(b);
        chk(b === 1'b0, "R7 fresh reset sets latch", b, 0);
        model[9'h048] = 8'h99;
        wait_commit();
        check_at(9'h048, "R5 single byte commit");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule